// File: doc/BRIEF.md
# Watchdog Reset Timer

This block is a programmable watchdog that drives an active-low reset. Software loads an 8-bit time value and enables the timer. The count then falls by one for each elapsed unit. The unit is one second or one minute, and both are built from a millisecond tick input. Software keeps the system alive by writing the time value again before the count reaches zero. The block holds its registers itself and provides a simple register write port and a combinational read port.

When a nonzero count reaches zero, the block sets a sticky status flag. If the output enable is set, it also drives the reset pin low. The pin can stay low as a level until software intervenes, or it can give one pulse lasting 1, 25, 125 or 5000 milliseconds, chosen by a 2-bit code. The block's `rst_n` input is the power-on reset domain and is kept separate from the pin this block drives. The status flag therefore survives the reset the block causes, and software can read it afterwards to learn why the system restarted. With the default parameters the longest timeout is 255 minutes.

Top module: `wdt_reset_timer`

## Requirements
- R1: After `rst_n` every register reads zero, addresses 0 to 3 all read 0x00 and `wdt_rst_n` is high.
- R2: A write to the time register (address 1) reloads the counter with the written value and restarts the unit prescaler. Reading address 1 returns the remaining count. Writing the value again before it reaches zero prevents expiry.
- R3: With the enable (control bit 0) set and the unit bit (control bit 1) clear, the count falls by one on every MS_PER_SEC-th millisecond tick.
- R4: With the unit bit set, the count falls by one on every (MS_PER_SEC x SEC_PER_MIN)-th millisecond tick.
- R5: Clearing the enable freezes the count and clears the prescaler. A count of zero never expires.
- R6: Expiry sets the status flag (control bit 7). Writing 1 to bit 7 clears it, and an expiry in the same cycle wins over the clear. The flag stays set while the pin is asserted and after the pin is released.
- R7: With the output enable (address 2, bit 0) clear, expiry sets the status flag and the pin stays high.
- R8: In level mode (control bit 2 clear) an expiry with the output enabled drives the pin low. The pin stays low until the time register is written or a control write clears the enable.
- R9: In pulse mode (control bit 2 set) the pin goes low for exactly N millisecond ticks after expiry. N is PW_T0, PW_T1, PW_T2 or PW_T3, selected by control bits 4:3 = 0, 1, 2, 3.
- R10: Only an expiry with the output enabled drives the pin low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_addr | input | 2 | Register address: 0 control, 1 time, 2 output enable |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tick_ms | input | 1 | One-cycle pulse once per millisecond |
| wdt_rst_n | output | 1 | Active-low watchdog reset output |

## Verification
The hardest situations to reach are the exact pulse lengths and the minute time base. Both take many millisecond ticks before anything is visible at the pin. The bench overrides the prescaler and pulse parameters with small values and runs a behavioural model that it compares against the pin and the read port on every cycle. It fires the timer in each of the four pulse codes and measures the low time against the expected tick count. It also reads the count partway through a minute to show that a second boundary alone does not decrement it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int DATA_W = 8;
   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
   localparam logic [ADDR_W-1:0] ADDR_TIME  = 2'd1;
   localparam logic [ADDR_W-1:0] ADDR_OUTEN = 2'd2;

   localparam int B_EN     = 0;
   localparam int B_UNIT   = 1;
   localparam int B_PULSE  = 2;
   localparam int B_PW_LO  = 3;
   localparam int B_STATUS = 7;

   typedef struct packed {
      logic       status;
      logic [1:0] pw;
      logic       pulse;
      logic       minutes;
      logic       en;
   } ctrl_t;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
   parameter int unsigned MS_PER_SEC  = 1000,
   parameter int unsigned SEC_PER_MIN = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic minutes,
   input  logic tick_ms,
   output logic unit_tick
);
   localparam int MSW = (MS_PER_SEC  > 1) ? $clog2(MS_PER_SEC)  : 1;
   localparam int SW  = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;

   logic ms_wrap;
   logic sec_last;

   if (MS_PER_SEC < 1) begin : g_bad_ms
      $error("MS_PER_SEC must be at least 1");
   end
   if (SEC_PER_MIN < 1) begin : g_bad_sec
      $error("SEC_PER_MIN must be at least 1");
   end

   if (MS_PER_SEC > 1) begin : g_ms_div
      logic [MSW-1:0] ms_q;
      assign ms_wrap = tick_ms && (ms_q == MSW'(MS_PER_SEC - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        ms_q <= '0;
         else if (clear)    ms_q <= '0;
         else if (ms_wrap)  ms_q <= '0;
         else if (tick_ms)  ms_q <= ms_q + 1'b1;
      end
   end else begin : g_ms_pass
      assign ms_wrap = tick_ms;
   end

   if (SEC_PER_MIN > 1) begin : g_sec_div
      logic [SW-1:0] sec_q;
      assign sec_last = (sec_q == SW'(SEC_PER_MIN - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    sec_q <= '0;
         else if (clear)                sec_q <= '0;
         else if (ms_wrap && minutes)   sec_q <= sec_last ? '0 : sec_q + 1'b1;
      end
   end else begin : g_sec_pass
      assign sec_last = 1'b1;
   end

   assign unit_tick = !clear && ms_wrap && (!minutes || sec_last);
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic [CNT_W-1:0] cnt_q,
   output logic             expire
);
   if (CNT_W < 1) begin : g_bad_w
      $error("CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load)                   cnt_q <= load_val;
      else if (step && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expire = step && !load && (cnt_q == CNT_W'(1));

   // R2: without a reload the count can only fall or hold
   assert_no_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/wdt_outgen.sv
module wdt_outgen #(
   parameter int unsigned PW_T0 = 1,
   parameter int unsigned PW_T1 = 25,
   parameter int unsigned PW_T2 = 125,
   parameter int unsigned PW_T3 = 5000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm,
   input  logic       pulse_mode,
   input  logic [1:0] pw_code,
   input  logic       tick_ms,
   input  logic       clear_level,
   output logic       active
);
   import wdt_pkg::*;

   localparam int unsigned PW_MAX = max4(PW_T0, PW_T1, PW_T2, PW_T3);
   localparam int PCW = $clog2(PW_MAX + 1);
   localparam int unsigned TBL [4] = '{PW_T0, PW_T1, PW_T2, PW_T3};

   logic [PCW-1:0] width_tbl [4];
   logic [PCW-1:0] pw_cnt;
   logic           act_pulse;

   for (genvar i = 0; i < 4; i++) begin : g_width
      if (TBL[i] < 1) begin : g_bad
         $error("pulse widths must be at least one tick");
      end
      assign width_tbl[i] = PCW'(TBL[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         act_pulse <= 1'b0;
         pw_cnt    <= '0;
      end else if (arm) begin
         active    <= 1'b1;
         act_pulse <= pulse_mode;
         pw_cnt    <= width_tbl[pw_code];
      end else if (active) begin
         if (act_pulse) begin
            if (tick_ms) begin
               if (pw_cnt <= PCW'(1)) active <= 1'b0;
               else                   pw_cnt <= pw_cnt - 1'b1;
            end
         end else if (clear_level) begin
            active <= 1'b0;
         end
      end
   end

   // R8: a level assertion persists until a clearing event
   assert_level_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !act_pulse && !clear_level) |=> active);
   // R9: a running pulse always has ticks left
   assert_pulse_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && act_pulse) |-> (pw_cnt != '0));
endmodule

// File: rtl/wdt_reset_timer.sv
module wdt_reset_timer #(
   parameter int unsigned MS_PER_SEC  = 1000,
   parameter int unsigned SEC_PER_MIN = 60,
   parameter int unsigned PW_T0       = 1,
   parameter int unsigned PW_T1       = 25,
   parameter int unsigned PW_T2       = 125,
   parameter int unsigned PW_T3       = 5000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  reg_addr,
   input  logic        reg_wr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   input  logic        tick_ms,
   output logic        wdt_rst_n
);
   import wdt_pkg::*;

   ctrl_t              ctrl_q;
   logic               outen_q;
   logic [DATA_W-1:0]  cnt_q;
   logic               wr_ctrl, wr_time, wr_outen, ctrl_off;
   logic               tb_clear, unit_tick, expire, active;

   assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
   assign wr_time  = reg_wr && (reg_addr == ADDR_TIME);
   assign wr_outen = reg_wr && (reg_addr == ADDR_OUTEN);
   assign ctrl_off = wr_ctrl && !reg_wdata[B_EN];
   assign tb_clear = !ctrl_q.en || wr_time || ctrl_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         outen_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.en      <= reg_wdata[B_EN];
            ctrl_q.minutes <= reg_wdata[B_UNIT];
            ctrl_q.pulse   <= reg_wdata[B_PULSE];
            ctrl_q.pw      <= reg_wdata[B_PW_LO +: 2];
         end
         if (expire)                            ctrl_q.status <= 1'b1;
         else if (wr_ctrl && reg_wdata[B_STATUS]) ctrl_q.status <= 1'b0;
         if (wr_outen) outen_q <= reg_wdata[0];
      end
   end

   wdt_timebase #(.MS_PER_SEC(MS_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN)) u_timebase (
      .clk(clk), .rst_n(rst_n), .clear(tb_clear), .minutes(ctrl_q.minutes),
      .tick_ms(tick_ms), .unit_tick(unit_tick));

   wdt_downcount #(.CNT_W(DATA_W)) u_count (
      .clk(clk), .rst_n(rst_n), .load(wr_time), .load_val(reg_wdata),
      .step(unit_tick), .cnt_q(cnt_q), .expire(expire));

   wdt_outgen #(.PW_T0(PW_T0), .PW_T1(PW_T1), .PW_T2(PW_T2), .PW_T3(PW_T3)) u_out (
      .clk(clk), .rst_n(rst_n), .arm(expire && outen_q), .pulse_mode(ctrl_q.pulse),
      .pw_code(ctrl_q.pw), .tick_ms(tick_ms), .clear_level(wr_time || ctrl_off),
      .active(active));

   always_comb begin
      case (reg_addr)
         ADDR_CTRL:  reg_rdata = {ctrl_q.status, 2'b00, ctrl_q.pw, ctrl_q.pulse,
                                  ctrl_q.minutes, ctrl_q.en};
         ADDR_TIME:  reg_rdata = cnt_q;
         ADDR_OUTEN: reg_rdata = {7'b0, outen_q};
         default:    reg_rdata = '0;
      endcase
   end

   assign wdt_rst_n = ~active;

   // R5: a zero count that is not reloaded never starts an assertion
   assert_zero_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !wr_time) |=> !$rose(active));
   // R6: the status flag only drops through a write-one clear
   assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.status && !(wr_ctrl && reg_wdata[B_STATUS])) |=> ctrl_q.status);
   // R7: the pin falls only while the output enable was set
   assert_pin_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdt_rst_n) |-> $past(outen_q));
endmodule

// File: tb/wdt_reset_timer_bench.sv
module wdt_reset_timer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MPS = 4;
   localparam int SPM = 3;
   localparam int PWV [4] = '{1, 2, 3, 5};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       tick_ms = 1'b0;
   logic       wdt_rst_n;

   int checks = 0;
   int failures = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_reset_timer #(.MS_PER_SEC(MPS), .SEC_PER_MIN(SPM),
                     .PW_T0(1), .PW_T1(2), .PW_T2(3), .PW_T3(5)) u_wdt_reset_timer (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_ms(tick_ms),
      .wdt_rst_n(wdt_rst_n));

   // millisecond tick: one cycle in three
   int tcnt = 0;
   always @(negedge clk) begin
      tcnt    <= (tcnt == 2) ? 0 : tcnt + 1;
      tick_ms <= (tcnt == 2);
   end

   // behavioural reference model
   int m_en, m_unit, m_pulse, m_pw, m_status, m_outen, m_cnt;
   int m_ms, m_sec, m_active, m_apulse, m_pwc;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_unit = 0; m_pulse = 0; m_pw = 0; m_status = 0; m_outen = 0;
         m_cnt = 0; m_ms = 0; m_sec = 0; m_active = 0; m_apulse = 0; m_pwc = 0;
      end else begin
         bit cw, tw, ow, off, clr, wrap, ut, ex;
         cw   = reg_wr && reg_addr == 0;
         tw   = reg_wr && reg_addr == 1;
         ow   = reg_wr && reg_addr == 2;
         off  = cw && !reg_wdata[0];
         clr  = (m_en == 0) || tw || off;
         wrap = tick_ms && (m_ms == MPS - 1);
         ut   = !clr && wrap && (m_unit == 0 || m_sec == SPM - 1);
         ex   = ut && (m_cnt == 1);
         if (clr) begin m_ms = 0; m_sec = 0; end
         else if (tick_ms) begin
            if (wrap) begin
               m_ms = 0;
               if (m_unit != 0) m_sec = (m_sec == SPM - 1) ? 0 : m_sec + 1;
            end else m_ms = m_ms + 1;
         end
         if (tw) m_cnt = reg_wdata;
         else if (ut && m_cnt != 0) m_cnt = m_cnt - 1;
         if (ex && m_outen != 0) begin
            m_active = 1; m_apulse = m_pulse; m_pwc = PWV[m_pw];
         end else if (m_active != 0) begin
            if (m_apulse != 0) begin
               if (tick_ms) begin
                  if (m_pwc <= 1) m_active = 0; else m_pwc = m_pwc - 1;
               end
            end else if (tw || off) m_active = 0;
         end
         if (ex) m_status = 1;
         else if (cw && reg_wdata[7]) m_status = 0;
         if (cw) begin
            m_en = reg_wdata[0]; m_unit = reg_wdata[1];
            m_pulse = reg_wdata[2]; m_pw = reg_wdata[4:3];
         end
         if (ow) m_outen = reg_wdata[0];
      end
   end

   function automatic int exp_rdata(input logic [1:0] a);
      case (a)
         2'd0: return (m_status << 7) | (m_pw << 3) | (m_pulse << 2) | (m_unit << 1) | m_en;
         2'd1: return m_cnt;
         2'd2: return m_outen;
         default: return 0;
      endcase
   endfunction

   task automatic check(input string req, input string what, input int act, input int expv);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      #1;
      if (rst_n && cmp_on && !done) begin
         check("R10", "pin vs model", wdt_rst_n, (m_active != 0) ? 0 : 1);
         check("R2", "read port vs model", reg_rdata, exp_rdata(reg_addr));
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_check(input logic [1:0] a, input int expv, input string req);
      @(negedge clk);
      reg_addr = a;
      #2;
      check(req, "register read", reg_rdata, expv);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_pin_low(input int maxc, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < maxc && !seen; i++) begin
         @(negedge clk); #2;
         if (wdt_rst_n == 1'b0) seen = 1'b1;
      end
   endtask

   // watchdog of the bench itself
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL R1 bench watchdog actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      bit seen;
      int lows, held;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      rd_check(2'd0, 0, "R1");
      rd_check(2'd1, 0, "R1");
      rd_check(2'd2, 0, "R1");
      rd_check(2'd3, 0, "R1");
      check("R1", "pin after reset", wdt_rst_n, 1);
      cmp_on = 1'b1;

      // R3/R8: seconds, level mode
      wr(2'd2, 8'h01);
      wr(2'd1, 8'd3);
      wr(2'd0, 8'h01);
      wait_pin_low(300, seen);
      check("R3", "expiry in seconds mode", seen, 1);
      rd_check(2'd0, 8'h81, "R6");
      rd_check(2'd1, 0, "R3");
      idle(40);
      check("R8", "level held", wdt_rst_n, 0);
      wr(2'd1, 8'd5);
      #2;
      check("R8", "level released by time write", wdt_rst_n, 1);
      wr(2'd0, 8'h80);
      rd_check(2'd0, 8'h00, "R6");

      // R4: minutes mode
      wr(2'd1, 8'd2);
      wr(2'd0, 8'h03);
      idle(20);
      rd_check(2'd1, 2, "R4");
      wait_pin_low(400, seen);
      check("R4", "expiry in minutes mode", seen, 1);
      rd_check(2'd0, 8'h83, "R6");
      wr(2'd0, 8'h80);
      #2;
      check("R8", "level released by disable", wdt_rst_n, 1);

      // R9: pulse widths for all four codes
      for (int c = 0; c < 4; c++) begin
         wr(2'd1, 8'd1);
         wr(2'd0, 8'(8'h05 | (c << 3)));
         wait_pin_low(100, seen);
         check("R9", "pulse started", seen, 1);
         lows = 1;
         for (int i = 0; i < 60 && wdt_rst_n == 1'b0; i++) begin
            @(negedge clk); #2;
            if (wdt_rst_n == 1'b0) lows++;
         end
         check("R9", "pulse length in cycles", lows, 3 * PWV[c]);
         rd_check(2'd0, 8'(8'h85 | (c << 3)), "R6");
         wr(2'd0, 8'h80);
      end

      // R7: output disabled
      wr(2'd2, 8'h00);
      wr(2'd1, 8'd1);
      wr(2'd0, 8'h01);
      lows = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); #2;
         if (wdt_rst_n == 1'b0) lows++;
      end
      check("R7", "pin idle with output disabled", lows, 0);
      rd_check(2'd0, 8'h81, "R7");
      wr(2'd0, 8'h80);

      // R5: zero never fires; disable freezes the count
      wr(2'd2, 8'h01);
      wr(2'd1, 8'd0);
      wr(2'd0, 8'h01);
      idle(60);
      rd_check(2'd0, 8'h01, "R5");
      wr(2'd1, 8'd9);
      idle(30);
      wr(2'd0, 8'h00);
      @(negedge clk); reg_addr = 2'd1; #2;
      held = reg_rdata;
      idle(60);
      rd_check(2'd1, held, "R5");
      check("R5", "count moved before disable", (held < 9) ? 1 : 0, 1);

      // R2: repeated kicks keep the timer from expiring
      wr(2'd1, 8'd2);
      wr(2'd0, 8'h01);
      lows = 0;
      for (int k = 0; k < 10; k++) begin
         for (int i = 0; i < 12; i++) begin
            @(negedge clk); #2;
            if (wdt_rst_n == 1'b0) lows++;
         end
         wr(2'd1, 8'd2);
      end
      check("R2", "no expiry while kicked", lows, 0);
      rd_check(2'd0, 8'h01, "R2");
      wr(2'd0, 8'h00);

      // R6: expiry wins over a same-cycle clear is covered by the model;
      // here the flag is also shown to stay after a pulse ends
      wr(2'd1, 8'd1);
      wr(2'd0, 8'h05);
      wait_pin_low(100, seen);
      idle(20);
      check("R6", "pin released after pulse", wdt_rst_n, 1);
      rd_check(2'd0, 8'h85, "R6");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule